// File: doc/BRIEF.md
# SPI Register Target with Alignment Preamble and Optional CRC Frames

This block is an SPI target that gives a host read and write access to a small bank of 8-bit registers. Every transaction is one frame framed by an active-low chip select. The host sends a command bit (0 = write, 1 = read), a 7-bit register address and a data byte, all MSB first. The target samples SDI on rising SCLK edges and changes SDO on falling SCLK edges, so both SPI mode 0 and mode 3 work. SDO is an open-drain line. The block only ever asks for it to be pulled low, and it leaves the line to an external pull-up the rest of the time.

While the header goes in, SDO sends a fixed preamble so the host can check bit alignment. In a read, the addressed register then follows on SDO. One bit of control register 0 turns on CRC frames. A CRC frame is 24 bits long and carries an extra check byte. The CRC arithmetic sits in a separate checker block. That block sees the frame payload and the received check byte, returns a match flag, and supplies the byte that the target sends back during reads.

All SPI pins are brought into the system clock domain through synchronizers, and the frame logic runs on the edges it detects there. The system clock must therefore be several times faster than SCLK.

Top module: `spi_regbank_target`

## Requirements
- R1: After reset, every register reads 0, CRC mode (register 0, bit 0) is off, and SDO is released (`sdo_pull_low` = 0, `sdo_value` = 1).
- R2: SDO is pulled low only inside a frame. After chip select returns high, SDO is released.
- R3: In every frame, SDO bits 1 to 8 carry the constant 0x25, MSB first. Bit 1 is valid from the falling edge of chip select (mode 0) or from the first SCLK fall (mode 3).
- R4: Frame bit 1 is the command (0 = write, 1 = read). Bits 2 to 8 are the register address and bits 9 to 16 are the data, both MSB first. Frames in SPI mode 0 and SPI mode 3 behave the same.
- R5: In a read, SDO bits 9 to 16 carry the addressed register, MSB first. The data bits on SDI are ignored and change no register.
- R6: Without CRC, a write commits on the 16th rising SCLK edge. During a write, SDO stays released after the preamble.
- R7: If chip select rises before the frame length is reached, the frame is dropped without a write. Bits clocked after the frame length is reached are ignored.
- R8: Addresses at or above the number of registers are not backed by storage. Writes to them change nothing, and reads of them return 0.
- R9: The CRC mode in force is sampled when chip select falls. Frames are 24 bits long with CRC on and 16 bits long with CRC off.
- R10: In a CRC read, SDO bits 17 to 24 carry `crc_tx_byte`. The checker forms that byte over `frame_payload` = {command, address, register data}.
- R11: In CRC mode, a write commits at the 24th rising edge only if `crc_match` is high. A write frame cut short to 16 bits does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low, frames a transaction |
| spi_sclk | input | 1 | SPI serial clock |
| spi_sdi | input | 1 | Serial data from host |
| sdo_pull_low | output | 1 | Asks the open-drain SDO line to be pulled low |
| sdo_value | output | 1 | Logical SDO bit (1 when released) |
| crc_mode | output | 1 | Current CRC enable bit from the control register |
| frame_payload | output | 16 | Command, address and data byte of the current frame, for the CRC checker |
| frame_crc_rx | output | 8 | Check byte received in a CRC write frame |
| crc_tx_byte | input | 8 | Check byte from the CRC checker, sent in CRC reads |
| crc_match | input | 1 | CRC checker reports that the received byte matches the payload |

## Verification
The assertions assume that SCLK and chip select stay at each level for at least three system clocks. Under that assumption every pin change is seen after synchronization, and no SCLK edge is merged with a chip select edge. The assertions also assume that the CRC checker's inputs are settled when the frame's last bit has been taken. The bench drives SPI at sixteen system clocks per SCLK period and leaves several half-periods between the last SCLK edge and chip select. It models the CRC checker with combinational logic directly from the block's outputs.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
   localparam int HDR_BITS   = 8;
   localparam int DATA_BITS  = 8;
   localparam int CHK_BITS   = 8;
   localparam int ADDR_BITS  = HDR_BITS - 1;
   localparam int BASE_LEN   = HDR_BITS + DATA_BITS;
   localparam int CRC_LEN    = BASE_LEN + CHK_BITS;
   localparam int CNT_W      = $clog2(CRC_LEN + 1);
   localparam logic [HDR_BITS-1:0] ALIGN_WORD = 8'h25;

   typedef logic [CNT_W-1:0] bitcnt_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_in,
   input  logic sclk_in,
   input  logic sdi_in,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic frame_start,
   output logic frame_end,
   output logic in_frame,
   output logic sdi_bit
);
   // bit 2 = chip select, bit 1 = clock, bit 0 = data
   localparam logic [2:0] IDLE_VAL = 3'b100;

   logic [2:0] chain_q [STAGES];
   logic       sclk_prev_q;
   logic       cs_prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= IDLE_VAL;
            else        chain_q[s] <= {cs_n_in, sclk_in, sdi_in};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= IDLE_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   logic cs_s, sclk_s;
   assign cs_s   = chain_q[STAGES-1][2];
   assign sclk_s = chain_q[STAGES-1][1];
   assign sdi_bit = chain_q[STAGES-1][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
         cs_prev_q   <= 1'b1;
      end else begin
         sclk_prev_q <= sclk_s;
         cs_prev_q   <= cs_s;
      end
   end

   assign in_frame    = ~cs_s;
   assign sclk_rise   = sclk_s & ~sclk_prev_q;
   assign sclk_fall   = ~sclk_s & sclk_prev_q;
   assign frame_start = cs_prev_q & ~cs_s;
   assign frame_end   = ~cs_prev_q & cs_s;
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import spi_regbank_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk_rise,
   input  logic                 frame_start,
   input  logic                 frame_end,
   input  logic                 in_frame,
   input  logic                 sdi_bit,
   input  logic                 crc_mode,
   input  logic                 crc_match,
   input  logic [DATA_BITS-1:0] rd_data,
   output logic [ADDR_BITS-1:0] rd_addr,
   output bitcnt_t              bit_cnt,
   output logic                 crc_frame,
   output logic                 is_read,
   output logic [DATA_BITS-1:0] rdata,
   output logic                 wr_en,
   output logic [ADDR_BITS-1:0] wr_addr,
   output logic [DATA_BITS-1:0] wr_data,
   output logic [BASE_LEN-1:0]  payload,
   output logic [CHK_BITS-1:0]  crc_rx
);
   logic [CRC_LEN-1:0]   rx_q;
   logic [HDR_BITS-1:0]  hdr_q;
   logic [DATA_BITS-1:0] wdata_q;
   logic [DATA_BITS-1:0] rdata_q;
   logic                 addr_take_q;
   logic                 commit_q;
   bitcnt_t              frame_len;
   logic [7:0]           shift_in;
   logic                 take;

   assign frame_len = crc_frame ? bitcnt_t'(CRC_LEN) : bitcnt_t'(BASE_LEN);
   assign shift_in  = {rx_q[6:0], sdi_bit};
   assign take      = sclk_rise & in_frame & (bit_cnt < frame_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q        <= '0;
         hdr_q       <= '0;
         wdata_q     <= '0;
         rdata_q     <= '0;
         bit_cnt     <= '0;
         crc_frame   <= 1'b0;
         addr_take_q <= 1'b0;
         commit_q    <= 1'b0;
      end else begin
         addr_take_q <= 1'b0;
         commit_q    <= 1'b0;
         if (frame_start) begin
            bit_cnt   <= '0;
            crc_frame <= crc_mode;
         end else if (frame_end) begin
            bit_cnt <= '0;
         end else if (take) begin
            rx_q    <= {rx_q[CRC_LEN-2:0], sdi_bit};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == bitcnt_t'(HDR_BITS - 1)) begin
               hdr_q       <= shift_in;
               addr_take_q <= 1'b1;
            end
            if (bit_cnt == bitcnt_t'(BASE_LEN - 1)) wdata_q <= shift_in;
            if (bit_cnt == frame_len - 1'b1)        commit_q <= 1'b1;
         end
         if (addr_take_q) rdata_q <= rd_data;
      end
   end

   assign rd_addr = hdr_q[ADDR_BITS-1:0];
   assign is_read = hdr_q[HDR_BITS-1];
   assign rdata   = rdata_q;
   assign wr_addr = hdr_q[ADDR_BITS-1:0];
   assign wr_data = wdata_q;
   assign wr_en   = commit_q & ~is_read & (~crc_frame | crc_match);
   assign payload = {hdr_q, is_read ? rdata_q : wdata_q};
   assign crc_rx  = rx_q[CHK_BITS-1:0];
endmodule

// File: rtl/spi_sdo_mux.sv
module spi_sdo_mux
   import spi_regbank_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk_fall,
   input  logic                 frame_start,
   input  logic                 frame_end,
   input  logic                 in_frame,
   input  bitcnt_t              bit_cnt,
   input  logic                 is_read,
   input  logic                 crc_frame,
   input  logic [DATA_BITS-1:0] rdata,
   input  logic [CHK_BITS-1:0]  crc_tx,
   output logic                 sdo_pull_low,
   output logic                 sdo_value
);
   logic [CRC_LEN-1:0] stream;
   logic               next_bit;
   logic               bit_q;

   assign stream = {ALIGN_WORD,
                    is_read ? rdata : {DATA_BITS{1'b1}},
                    (is_read & crc_frame) ? crc_tx : {CHK_BITS{1'b1}}};
   assign next_bit = (bit_cnt < bitcnt_t'(CRC_LEN))
                   ? stream[bitcnt_t'(CRC_LEN - 1) - bit_cnt] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       bit_q <= 1'b1;
      else if (frame_start)             bit_q <= ALIGN_WORD[HDR_BITS-1];
      else if (frame_end)               bit_q <= 1'b1;
      else if (sclk_fall && in_frame)   bit_q <= next_bit;
   end

   assign sdo_value    = bit_q;
   assign sdo_pull_low = ~bit_q;
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
   import spi_regbank_pkg::*;
#(
   parameter int NUM_REGS   = 4,
   parameter int CTRL_ADDR  = 0,
   parameter int CRC_EN_BIT = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_BITS-1:0]          wr_addr,
   input  logic [DATA_BITS-1:0]          wr_data,
   input  logic [ADDR_BITS-1:0]          rd_addr,
   output logic [DATA_BITS-1:0]          rd_data,
   output logic                          crc_mode,
   output logic [NUM_REGS*DATA_BITS-1:0] regs_flat
);
   logic [DATA_BITS-1:0] regs_q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[i] <= '0;
         else if (wr_en && wr_addr == ADDR_BITS'(i))
            regs_q[i] <= wr_data;
      end
      assign regs_flat[i*DATA_BITS +: DATA_BITS] = regs_q[i];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_addr == ADDR_BITS'(i)) rd_data = regs_q[i];
   end

   assign crc_mode = regs_q[CTRL_ADDR][CRC_EN_BIT];
endmodule

// File: rtl/spi_regbank_target.sv
module spi_regbank_target
   import spi_regbank_pkg::*;
#(
   parameter int NUM_REGS    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CTRL_ADDR   = 0,
   parameter int CRC_EN_BIT  = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                spi_cs_n,
   input  logic                spi_sclk,
   input  logic                spi_sdi,
   output logic                sdo_pull_low,
   output logic                sdo_value,
   output logic                crc_mode,
   output logic [BASE_LEN-1:0] frame_payload,
   output logic [CHK_BITS-1:0] frame_crc_rx,
   input  logic [CHK_BITS-1:0] crc_tx_byte,
   input  logic                crc_match
);
   localparam int REG_VEC_W = NUM_REGS * DATA_BITS;

   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_BITS)) begin : g_bad_num_regs
      $error("NUM_REGS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CTRL_ADDR < 0 || CTRL_ADDR >= NUM_REGS) begin : g_bad_ctrl
      $error("CTRL_ADDR must address a stored register");
   end
   if (CRC_EN_BIT < 0 || CRC_EN_BIT >= DATA_BITS) begin : g_bad_bit
      $error("CRC_EN_BIT outside the data byte");
   end

   logic                 sclk_rise, sclk_fall, frame_start, frame_end, in_frame, sdi_bit;
   bitcnt_t              bit_cnt;
   logic                 crc_frame, is_read, wr_en;
   logic [ADDR_BITS-1:0] rd_addr, wr_addr;
   logic [DATA_BITS-1:0] rd_data, rdata, wr_data;
   logic [REG_VEC_W-1:0] regs_flat;

   spi_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .cs_n_in(spi_cs_n), .sclk_in(spi_sclk), .sdi_in(spi_sdi),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .frame_start(frame_start), .frame_end(frame_end),
      .in_frame(in_frame), .sdi_bit(sdi_bit)
   );

   spi_frame_ctrl frame_i (
      .clk(clk), .rst_n(rst_n),
      .sclk_rise(sclk_rise), .frame_start(frame_start), .frame_end(frame_end),
      .in_frame(in_frame), .sdi_bit(sdi_bit),
      .crc_mode(crc_mode), .crc_match(crc_match), .rd_data(rd_data),
      .rd_addr(rd_addr), .bit_cnt(bit_cnt), .crc_frame(crc_frame),
      .is_read(is_read), .rdata(rdata), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .payload(frame_payload), .crc_rx(frame_crc_rx)
   );

   spi_sdo_mux sdo_i (
      .clk(clk), .rst_n(rst_n),
      .sclk_fall(sclk_fall), .frame_start(frame_start), .frame_end(frame_end),
      .in_frame(in_frame), .bit_cnt(bit_cnt), .is_read(is_read),
      .crc_frame(crc_frame), .rdata(rdata), .crc_tx(crc_tx_byte),
      .sdo_pull_low(sdo_pull_low), .sdo_value(sdo_value)
   );

   spi_reg_file #(
      .NUM_REGS(NUM_REGS), .CTRL_ADDR(CTRL_ADDR), .CRC_EN_BIT(CRC_EN_BIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .crc_mode(crc_mode), .regs_flat(regs_flat)
   );
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk
   import spi_regbank_pkg::*;
#(
   parameter int NUM_REGS = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         sclk_fall,
   input logic                         frame_start,
   input logic                         frame_end,
   input logic                         sdo_pull_low,
   input bitcnt_t                      bit_cnt,
   input logic                         crc_frame,
   input logic                         crc_match,
   input logic                         wr_en,
   input logic [NUM_REGS*DATA_BITS-1:0] regs_flat
);
   // R2
   sdo_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo_pull_low) |-> $past(sclk_fall | frame_start | frame_end));

   // R6
   reg_write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_flat) |-> $past(wr_en));

   // R11
   crc_write_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(regs_flat) && crc_frame) |-> $past(crc_match));

   // R7
   count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (bit_cnt == '0));

   // R7
   count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= bitcnt_t'(CRC_LEN));

   // R9
   crc_frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(crc_frame) |-> $past(frame_start));
endmodule

bind spi_regbank_target spi_regbank_chk #(.NUM_REGS(NUM_REGS)) chk_i (
   .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .frame_start(frame_start),
   .frame_end(frame_end), .sdo_pull_low(sdo_pull_low), .bit_cnt(bit_cnt),
   .crc_frame(crc_frame), .crc_match(crc_match), .wr_en(wr_en),
   .regs_flat(regs_flat)
);

// File: tb/spi_regbank_target_tb.sv
module spi_regbank_target_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic sdo_pull_low, sdo_value, crc_mode;
   logic [15:0] frame_payload;
   logic [7:0]  frame_crc_rx, crc_tx_byte;
   logic        crc_match;
   logic        bad_crc = 1'b0;
   int checks = 0, fails = 0, cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] crc8(input logic [15:0] d);
      logic [7:0] c = 8'h00;
      for (int i = 15; i >= 0; i--) begin
         logic fb = c[7] ^ d[i];
         c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return c;
   endfunction

   // CRC checker model
   assign crc_tx_byte = crc8(frame_payload);
   assign crc_match   = (crc8(frame_payload) == frame_crc_rx);

   spi_regbank_target dut_i (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
      .sdo_pull_low(sdo_pull_low), .sdo_value(sdo_value), .crc_mode(crc_mode),
      .frame_payload(frame_payload), .frame_crc_rx(frame_crc_rx),
      .crc_tx_byte(crc_tx_byte), .crc_match(crc_match)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [23:0] tx, input int n, input bit m3,
                       output logic [23:0] rx);
      rx = '1;
      @(negedge clk); sclk = m3;
      repeat (HALF) @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         if (m3) sclk = 1'b0;
         sdi = tx[23-i];
         repeat (HALF) @(negedge clk);
         rx[23-i] = ~sdo_pull_low;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         if (!m3) sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (4*HALF) @(negedge clk);
   endtask

   task automatic wr16(input logic [6:0] a, input logic [7:0] d, input bit m3);
      logic [23:0] rx;
      xfer({1'b0, a, d, 8'h00}, 16, m3, rx);
      chk("R3 write preamble", rx[23:16], 8'h25);
      chk("R6 write SDO released", rx[15:8], 8'hFF);
   endtask

   task automatic rd16(input logic [6:0] a, input bit m3, input logic [7:0] exp,
                       input string req);
      logic [23:0] rx;
      xfer({1'b1, a, 8'h00, 8'h00}, 16, m3, rx);
      chk("R3 read preamble", rx[23:16], 8'h25);
      chk(req, rx[15:8], exp);
   endtask

   task automatic wr24(input logic [6:0] a, input logic [7:0] d, input bit corrupt);
      logic [23:0] rx;
      logic [7:0]  c = crc8({1'b0, a, d}) ^ (corrupt ? 8'h01 : 8'h00);
      xfer({1'b0, a, d, c}, 24, 1'b0, rx);
      chk("R3 crc write preamble", rx[23:16], 8'h25);
   endtask

   task automatic rd24(input logic [6:0] a, input logic [7:0] exp, input string req);
      logic [23:0] rx;
      xfer({1'b1, a, 8'h00, 8'h00}, 24, 1'b0, rx);
      chk("R3 crc read preamble", rx[23:16], 8'h25);
      chk(req, rx[15:8], exp);
      chk("R10 crc byte on SDO", rx[7:0], crc8({1'b1, a, exp}));
   endtask

   task automatic t_reset;
      chk("R1 sdo released", sdo_pull_low, 1'b0);
      chk("R1 sdo value high", sdo_value, 1'b1);
      chk("R1 crc mode off", crc_mode, 1'b0);
      for (int r = 0; r < 4; r++) rd16(7'(r), 1'b0, 8'h00, "R1 reset value");
   endtask

   task automatic t_mode0_rw;
      wr16(7'd1, 8'hA5, 1'b0);
      wr16(7'd2, 8'h3C, 1'b0);
      wr16(7'd3, 8'h81, 1'b0);
      rd16(7'd1, 1'b0, 8'hA5, "R4 mode0 readback reg1");
      rd16(7'd2, 1'b0, 8'h3C, "R6 mode0 readback reg2");
      rd16(7'd3, 1'b0, 8'h81, "R4 mode0 readback reg3");
      chk("R2 released after frame", sdo_pull_low, 1'b0);
   endtask

   task automatic t_mode3_rw;
      wr16(7'd2, 8'h5A, 1'b1);
      rd16(7'd2, 1'b1, 8'h5A, "R4 mode3 readback");
      rd16(7'd2, 1'b0, 8'h5A, "R4 mode3 write seen in mode0");
   endtask

   task automatic t_read_ignores_sdi;
      logic [23:0] rx;
      xfer({1'b1, 7'd1, 8'hFF, 8'h00}, 16, 1'b0, rx);
      chk("R5 read data on SDO", rx[15:8], 8'hA5);
      rd16(7'd1, 1'b0, 8'hA5, "R5 read SDI data ignored");
   endtask

   task automatic t_out_of_range;
      wr16(7'h41, 8'h77, 1'b0);
      wr16(7'd4, 8'h66, 1'b0);
      rd16(7'h41, 1'b0, 8'h00, "R8 unbacked read 0x41");
      rd16(7'd4, 1'b0, 8'h00, "R8 unbacked read 0x04");
      rd16(7'd0, 1'b0, 8'h00, "R8 no alias into reg0");
      rd16(7'd1, 1'b0, 8'hA5, "R8 no alias into reg1");
   endtask

   task automatic t_abort_and_extra;
      logic [23:0] rx;
      xfer({1'b0, 7'd3, 8'hFF, 8'h00}, 10, 1'b0, rx);
      rd16(7'd3, 1'b0, 8'h81, "R7 aborted frame dropped");
      xfer({1'b0, 7'd3, 8'h42, 8'hF0}, 20, 1'b0, rx);
      rd16(7'd3, 1'b0, 8'h42, "R7 extra bits ignored");
   endtask

   task automatic t_crc;
      logic [23:0] rx;
      wr16(7'd0, 8'h01, 1'b0);
      chk("R9 crc mode on", crc_mode, 1'b1);
      rd24(7'd1, 8'hA5, "R9 crc read data");
      xfer({1'b0, 7'd1, 8'h11, 8'h00}, 16, 1'b0, rx);
      rd24(7'd1, 8'hA5, "R11 short frame no write");
      wr24(7'd1, 8'h22, 1'b1);
      rd24(7'd1, 8'hA5, "R11 bad crc rejected");
      wr24(7'd1, 8'h33, 1'b0);
      rd24(7'd1, 8'h33, "R11 good crc commits");
      wr24(7'd0, 8'h00, 1'b0);
      chk("R9 crc mode off", crc_mode, 1'b0);
      rd16(7'd1, 1'b0, 8'h33, "R9 back to 16 bit frames");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_mode0_rw();
      t_mode3_rw();
      t_read_ignores_sdi();
      t_out_of_range();
      t_abort_and_extra();
      t_crc();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles >= WATCHDOG) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule